// File: doc/BRIEF.md
# Message Receive Buffer with Overrun Policy

This block is a single-slot holding register for messages produced by a serial bus frame-receive engine. Each time the engine presents a validly received message, the block checks whether the slot is free. The message carries an identifier, a 4-bit data length and eight data bytes. If the slot is free, the block captures the whole message in one cycle and raises a buffer-full flag. Software reads the stored fields from the outputs and frees the slot by writing one to the full flag.

A message can arrive while the slot still holds unread contents. That is an overrun: one of the two messages is lost, and a sticky overrun flag is raised until software clears it. A lock-mode input chooses which message is lost. With locking off, the newcomer replaces the stored message, so the newest data is always readable. With locking on, the newcomer is dropped and the older message stays intact.

Top module: `rxbuf_top`

## Requirements
- R1: After a synchronous reset, `buf_full` and `buf_ovr` are 0.
- R2: When `msg_vld` is high and the slot is empty, `buf_id`, `buf_len` and `buf_data` show the offered message, and `buf_full` is 1, from the next clock edge on.
- R3: `buf_full` stays 1 until a cycle with `sw_clr_full` high. A clear with no message in the same cycle makes `buf_full` 0 at the next edge.
- R4: If `msg_vld` is high while `buf_full` is 1 and `sw_clr_full` is low, `buf_ovr` is 1 after the edge, in both lock modes.
- R5: With `lock_mode` = 0, a message that overruns replaces the stored identifier, length and data.
- R6: With `lock_mode` = 1, a message that overruns is discarded, and the stored identifier, length and data do not change.
- R7: `buf_ovr` is sticky. It is cleared only by `sw_clr_ovr`, and neither clearing the full flag nor reading changes it. A new overrun in the same cycle as `sw_clr_ovr` leaves it at 1.
- R8: A message in the same cycle as `sw_clr_full` is stored normally, `buf_full` stays 1, and no overrun is flagged.
- R9: The length field is 4 bits wide. An offered length above 8 (the byte count) is stored as 8, and a length of 8 or less is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_vld | input | 1 | One-cycle strobe: a valid message is offered |
| msg_id | input | ID_W (29) | Identifier of the offered message |
| msg_len | input | LEN_W (4) | Data length of the offered message |
| msg_data | input | 8*NBYTES (64) | Data bytes, byte 0 in bits 7:0 |
| lock_mode | input | 1 | 1 keeps the stored message on overrun, 0 overwrites it |
| sw_clr_full | input | 1 | Software write-one to the full flag, frees the slot |
| sw_clr_ovr | input | 1 | Software write-one to the overrun flag |
| buf_id | output | ID_W (29) | Stored identifier |
| buf_len | output | LEN_W (4) | Stored length, at most NBYTES |
| buf_data | output | 8*NBYTES (64) | Stored data bytes |
| buf_full | output | 1 | Slot holds an unread message |
| buf_ovr | output | 1 | Sticky overrun flag |

## Verification
Two pairs of events can coincide in one cycle. The first is a new message arriving in the same cycle that software frees the slot. The second is an overrun arriving in the same cycle that software clears the overrun flag. The bench sets up a full slot and then drives both strobes on one negative clock edge. In the first case it expects the new message to be stored with no overrun. In the second case it expects the overrun flag to remain set. In lock mode the bench also checks that the stored fields did not move, because a wrong priority between the strobes shows up either as a lost message or as a falsely cleared flag.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic {
    LOSS_NEWEST_WINS = 1'b0,
    LOSS_KEEP_OLDEST = 1'b1
  } loss_policy_e;

endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic msg_vld,
  input  logic lock_mode,
  input  logic sw_clr_full,
  input  logic sw_clr_ovr,
  output logic wr_en,
  output logic full_q,
  output logic ovr_q
);

  loss_policy_e policy;
  logic         full_eff;
  logic         overrun;

  always_comb begin
    policy   = loss_policy_e'(lock_mode);
    // a clear in this cycle frees the slot for a message in the same cycle
    full_eff = full_q & ~sw_clr_full;
    overrun  = msg_vld & full_eff;
    wr_en    = msg_vld & (~full_eff | (policy == LOSS_NEWEST_WINS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= wr_en | full_eff;
      // a new overrun wins over a clear in the same cycle
      ovr_q  <= overrun | (ovr_q & ~sw_clr_ovr);
    end
  end

endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int ID_W   = 29,
  parameter int LEN_W  = 4,
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [ID_W-1:0]       in_id,
  input  logic [LEN_W-1:0]      in_len,
  input  logic [8*NBYTES-1:0]   in_data,
  output logic [ID_W-1:0]       out_id,
  output logic [LEN_W-1:0]      out_len,
  output logic [8*NBYTES-1:0]   out_data
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(NBYTES);

  logic [LEN_W-1:0] len_c;

  always_comb begin
    len_c = (in_len > LEN_MAX) ? LEN_MAX : in_len;
  end

  // payload storage carries no reset so it maps onto plain enabled registers
  always_ff @(posedge clk) begin
    if (wr_en) begin
      out_id  <= in_id;
      out_len <= len_c;
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en) out_data[8*g +: 8] <= in_data[8*g +: 8];
    end
  end

endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top #(
  parameter int ID_W   = 29,
  parameter int LEN_W  = 4,
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  msg_vld,
  input  logic [ID_W-1:0]       msg_id,
  input  logic [LEN_W-1:0]      msg_len,
  input  logic [8*NBYTES-1:0]   msg_data,
  input  logic                  lock_mode,
  input  logic                  sw_clr_full,
  input  logic                  sw_clr_ovr,
  output logic [ID_W-1:0]       buf_id,
  output logic [LEN_W-1:0]      buf_len,
  output logic [8*NBYTES-1:0]   buf_data,
  output logic                  buf_full,
  output logic                  buf_ovr
);

  logic wr_en;

  rxbuf_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .msg_vld     (msg_vld),
    .lock_mode   (lock_mode),
    .sw_clr_full (sw_clr_full),
    .sw_clr_ovr  (sw_clr_ovr),
    .wr_en       (wr_en),
    .full_q      (buf_full),
    .ovr_q       (buf_ovr)
  );

  rxbuf_store #(
    .ID_W   (ID_W),
    .LEN_W  (LEN_W),
    .NBYTES (NBYTES)
  ) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .in_id    (msg_id),
    .in_len   (msg_len),
    .in_data  (msg_data),
    .out_id   (buf_id),
    .out_len  (buf_len),
    .out_data (buf_data)
  );

endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int ID_W   = 29,
  parameter int LEN_W  = 4,
  parameter int NBYTES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  msg_vld,
  input logic [ID_W-1:0]       msg_id,
  input logic [LEN_W-1:0]      msg_len,
  input logic [8*NBYTES-1:0]   msg_data,
  input logic                  lock_mode,
  input logic                  sw_clr_full,
  input logic                  sw_clr_ovr,
  input logic [ID_W-1:0]       buf_id,
  input logic [LEN_W-1:0]      buf_len,
  input logic [8*NBYTES-1:0]   buf_data,
  input logic                  buf_full,
  input logic                  buf_ovr
);

  p_full_after_msg_r2: assert property (@(posedge clk) disable iff (rst)
    msg_vld |=> buf_full);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !sw_clr_full) |=> buf_full);

  p_ovr_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && buf_full && !sw_clr_full) |=> buf_ovr);

  p_overwrite_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && buf_full && !sw_clr_full && !lock_mode)
      |=> (buf_id == $past(msg_id) && buf_data == $past(msg_data)));

  p_lock_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && buf_full && !sw_clr_full && lock_mode)
      |=> ($stable(buf_id) && $stable(buf_len) && $stable(buf_data)));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (buf_ovr && !sw_clr_ovr) |=> buf_ovr);

  p_clear_race_r8: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && sw_clr_full && !buf_ovr)
      |=> (!buf_ovr && buf_id == $past(msg_id)));

  p_len_cap_r9: assert property (@(posedge clk) disable iff (rst)
    buf_full |-> (buf_len <= LEN_W'(NBYTES)));

endmodule

bind rxbuf_top rxbuf_checker #(
  .ID_W   (ID_W),
  .LEN_W  (LEN_W),
  .NBYTES (NBYTES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .msg_vld     (msg_vld),
  .msg_id      (msg_id),
  .msg_len     (msg_len),
  .msg_data    (msg_data),
  .lock_mode   (lock_mode),
  .sw_clr_full (sw_clr_full),
  .sw_clr_ovr  (sw_clr_ovr),
  .buf_id      (buf_id),
  .buf_len     (buf_len),
  .buf_data    (buf_data),
  .buf_full    (buf_full),
  .buf_ovr     (buf_ovr)
);

// File: tb/rxbuf_top_bench.sv
module rxbuf_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_vld = 1'b0;
  logic [28:0] msg_id = '0;
  logic [3:0]  msg_len = '0;
  logic [63:0] msg_data = '0;
  logic        lock_mode = 1'b0;
  logic        sw_clr_full = 1'b0;
  logic        sw_clr_ovr = 1'b0;
  logic [28:0] buf_id;
  logic [3:0]  buf_len;
  logic [63:0] buf_data;
  logic        buf_full;
  logic        buf_ovr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rxbuf_top u_rxbuf_top (
    .clk(clk), .rst(rst), .msg_vld(msg_vld), .msg_id(msg_id),
    .msg_len(msg_len), .msg_data(msg_data), .lock_mode(lock_mode),
    .sw_clr_full(sw_clr_full), .sw_clr_ovr(sw_clr_ovr),
    .buf_id(buf_id), .buf_len(buf_len), .buf_data(buf_data),
    .buf_full(buf_full), .buf_ovr(buf_ovr)
  );

  localparam logic [28:0] ID_A = 29'h0ABC_1234;
  localparam logic [28:0] ID_B = 29'h1555_0F0F;
  localparam logic [28:0] ID_C = 29'h0000_07FF;
  localparam logic [28:0] ID_D = 29'h1234_5678;
  localparam logic [63:0] DA = 64'h0807_0605_0403_0201;
  localparam logic [63:0] DB = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] DC = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DD = 64'hDEAD_BEEF_CAFE_F00D;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, outputs sampled 1 ns after the capturing edge
  task automatic cyc(input logic v, input logic [28:0] id, input logic [3:0] len,
                     input logic [63:0] d, input logic cf, input logic co);
    @(negedge clk);
    msg_vld = v; msg_id = id; msg_len = len; msg_data = d;
    sw_clr_full = cf; sw_clr_ovr = co;
    @(posedge clk);
    #1;
    msg_vld = 1'b0; sw_clr_full = 1'b0; sw_clr_ovr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic clear_all();
    cyc(1'b0, '0, '0, '0, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    chk("R1", "full", 64'(buf_full), 64'd0);
    chk("R1", "ovr", 64'(buf_ovr), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_store_and_hold();
    lock_mode = 1'b0;
    cyc(1'b1, ID_A, 4'd8, DA, 1'b0, 1'b0);
    chk("R2", "full", 64'(buf_full), 64'd1);
    chk("R2", "id", 64'(buf_id), 64'(ID_A));
    chk("R2", "len", 64'(buf_len), 64'd8);
    chk("R2", "data", buf_data, DA);
    chk("R2", "no ovr", 64'(buf_ovr), 64'd0);
    idle(4);
    chk("R3", "full held", 64'(buf_full), 64'd1);
    cyc(1'b0, '0, '0, '0, 1'b1, 1'b0);
    chk("R3", "full cleared", 64'(buf_full), 64'd0);
    chk("R3", "ovr untouched", 64'(buf_ovr), 64'd0);
  endtask

  task automatic t_overwrite();
    clear_all();
    lock_mode = 1'b0;
    cyc(1'b1, ID_A, 4'd3, DA, 1'b0, 1'b0);
    cyc(1'b1, ID_B, 4'd6, DB, 1'b0, 1'b0);
    chk("R4", "ovr set", 64'(buf_ovr), 64'd1);
    chk("R5", "id newest", 64'(buf_id), 64'(ID_B));
    chk("R5", "len newest", 64'(buf_len), 64'd6);
    chk("R5", "data newest", buf_data, DB);
    cyc(1'b0, '0, '0, '0, 1'b1, 1'b0);
    chk("R7", "ovr after full clear", 64'(buf_ovr), 64'd1);
    idle(2);
    chk("R7", "ovr sticky", 64'(buf_ovr), 64'd1);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b1);
    chk("R7", "ovr cleared", 64'(buf_ovr), 64'd0);
  endtask

  task automatic t_lock();
    clear_all();
    lock_mode = 1'b1;
    cyc(1'b1, ID_A, 4'd8, DA, 1'b0, 1'b0);
    cyc(1'b1, ID_B, 4'd2, DB, 1'b0, 1'b0);
    chk("R4", "ovr set locked", 64'(buf_ovr), 64'd1);
    chk("R6", "id kept", 64'(buf_id), 64'(ID_A));
    chk("R6", "len kept", 64'(buf_len), 64'd8);
    chk("R6", "data kept", buf_data, DA);
    chk("R6", "full", 64'(buf_full), 64'd1);
    cyc(1'b1, ID_C, 4'd1, DC, 1'b0, 1'b1);
    chk("R7", "set wins over clear", 64'(buf_ovr), 64'd1);
    chk("R6", "id still kept", 64'(buf_id), 64'(ID_A));
  endtask

  task automatic t_clear_race();
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b1);
    lock_mode = 1'b1;
    chk("R8", "precondition full", 64'(buf_full), 64'd1);
    cyc(1'b1, ID_D, 4'd4, DD, 1'b1, 1'b0);
    chk("R8", "full", 64'(buf_full), 64'd1);
    chk("R8", "no ovr", 64'(buf_ovr), 64'd0);
    chk("R8", "id", 64'(buf_id), 64'(ID_D));
    chk("R8", "data", buf_data, DD);
  endtask

  task automatic t_len();
    clear_all();
    lock_mode = 1'b0;
    cyc(1'b1, ID_C, 4'd13, DC, 1'b0, 1'b0);
    chk("R9", "len 13 capped", 64'(buf_len), 64'd8);
    cyc(1'b1, ID_C, 4'd15, DC, 1'b1, 1'b0);
    chk("R9", "len 15 capped", 64'(buf_len), 64'd8);
    cyc(1'b1, ID_C, 4'd5, DC, 1'b1, 1'b0);
    chk("R9", "len 5 kept", 64'(buf_len), 64'd5);
    cyc(1'b1, ID_C, 4'd0, DC, 1'b1, 1'b0);
    chk("R9", "len 0 kept", 64'(buf_len), 64'd0);
  endtask

  initial begin
    t_reset();
    t_store_and_hold();
    t_overwrite();
    t_lock();
    t_clear_race();
    t_len();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule